// File: doc/BRIEF.md
# Dual-Port Programmable Parallel Interface

This peripheral sits on a simple synchronous register bus and gives a processor two independent 8-bit I/O ports, A and B. Every pin of a port can be made an input or an output on its own. Mixed ports are allowed, for example six outputs driving a printer data path and two inputs sensing a ready line. Each port owns three registers: a direction register, an output latch and a configuration (control) register. Only two bus addresses per port are used. The even address is shared between the direction register and the port data, and a bit of the port's control register chooses which of the two the even address reaches.

Each port also has two handshake lines. The first is a sense input whose active edge raises a status flag. The second is a bidirectional auxiliary line. As an input it raises a second flag on its active edge. As an output it either drives a static level or gives a one-cycle low strobe after every processor write to the port data. A software sequence can therefore put a byte on the port and strobe it into an external device. Both flags can be read in the control register and cleared by reading the port data. Each flag can be routed to the port's interrupt output.

Top module: `dual_pio`

## Requirements
- R1: After reset all direction registers, output latches and control registers are zero. No pin or auxiliary line is driven (`*_oe` = 0), the auxiliary outputs idle high, both interrupts are low, and every control register reads 0x00.
- R2: Address 0 and 1 belong to port A and addresses 2 and 3 to port B, with the control register at the odd address. When control bit 2 is 0, the even address reads and writes the direction register. When it is 1, the even address reads and writes the port data. A write to one port leaves the other port unchanged.
- R3: A direction bit of 1 makes the pin an output (`*_oe` bit = 1) and 0 makes it an input. The pin output always carries the output latch.
- R4: A port data read returns the latch bit for output pins and, for input pins, the pin level sampled at the previous clock edge.
- R5: A control write stores bits 5:0. Bits 7:6 are read-only flags, and a control read returns {flag7, flag6, bits 5:0}.
- R6: Control bit 7 is set by an edge on the sense input. Bit 1 = 1 selects the rising edge and 0 the falling edge. The flag appears two clock edges after the input changes.
- R7: When control bit 5 is 0 the auxiliary line is an input, and its edge sets control bit 6. Bit 4 = 1 selects the rising edge and 0 the falling edge. When bit 5 is 1, edges on the auxiliary input are ignored.
- R8: A port data read clears control bits 7 and 6 of that port. If an active edge is detected in the same cycle as the clearing read, the flag stays set. A control read clears nothing.
- R9: The port interrupt is high exactly when (bit 7 and bit 0) or (bit 6 and bit 3 and not bit 5) hold.
- R10: With control bits 5:3 = 101 the auxiliary line is driven. It is high, and it goes low for exactly the one cycle that follows each port data write.
- R11: With control bits 5:3 = 11x the auxiliary line is driven to the value of bit 3. With 100 it is driven high. With bit 5 = 0 it is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Bus select for this block |
| wr_en | input | 1 | Write strobe, acted on at the clock edge |
| rd_en | input | 1 | Read strobe, qualifies read side effects |
| addr | input | 2 | Register offset |
| wdata | input | W | Write data |
| rdata | output | W | Read data, combinational from addr |
| pa_in | input | W | Port A pin levels |
| pa_out | output | W | Port A pin drive values |
| pa_oe | output | W | Port A per-pin output enable |
| a_sense_in | input | 1 | Port A edge-sense input |
| a_aux_in | input | 1 | Port A auxiliary line, input side |
| a_aux_out | output | 1 | Port A auxiliary line, drive value |
| a_aux_oe | output | 1 | Port A auxiliary line, drive enable |
| a_irq | output | 1 | Port A interrupt |
| pb_in | input | W | Port B pin levels |
| pb_out | output | W | Port B pin drive values |
| pb_oe | output | W | Port B per-pin output enable |
| b_sense_in | input | 1 | Port B edge-sense input |
| b_aux_in | input | 1 | Port B auxiliary line, input side |
| b_aux_out | output | 1 | Port B auxiliary line, drive value |
| b_aux_oe | output | 1 | Port B auxiliary line, drive enable |
| b_irq | output | 1 | Port B interrupt |

## Verification
The hardest case to reach is the race between a flag being cleared and being set. A port data read must land on the very clock edge at which a fresh sense-input edge reaches the flag, two edges after the pin moved. The bench reaches it by raising the sense input on a falling clock edge and then starting the read task, so the read strobe spans exactly the second rising edge. The one-cycle strobe is checked on two consecutive falling clock edges after a data write. This shows that the strobe is present and also that it ends.

// File: rtl/pio_pkg.sv
package pio_pkg;

    // control register bit positions
    localparam int CB_IRQ_EN   = 0;
    localparam int CB_SENSE_UP = 1;
    localparam int CB_DATA_SEL = 2;
    localparam int CB_AUX_LO   = 3;
    localparam int CB_AUX_MID  = 4;
    localparam int CB_AUX_DIR  = 5;
    localparam int CB_FLAG_AUX = 6;
    localparam int CB_FLAG_SNS = 7;
    localparam int CFG_W       = 6;
    localparam int CTL_W       = 8;

    typedef enum logic [1:0] {
        AUX_SENSE = 2'd0,
        AUX_PULSE = 2'd1,
        AUX_LEVEL = 2'd2,
        AUX_HIGH  = 2'd3
    } aux_mode_e;

    function automatic aux_mode_e aux_mode(input logic [2:0] f);
        if (!f[2])      return AUX_SENSE;
        else if (f[1])  return AUX_LEVEL;
        else if (f[0])  return AUX_PULSE;
        else            return AUX_HIGH;
    endfunction

endpackage

// File: rtl/pio_edge.sv
module pio_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic rise_sel,
    output logic hit
);
    typedef struct packed {
        logic cur;
        logic prev;
        logic primed;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.primed) begin
            st_d.cur    = din;
            st_d.prev   = din;
            st_d.primed = 1'b1;
        end else begin
            st_d.cur  = din;
            st_d.prev = st_q.cur;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit = st_q.primed &&
                 (rise_sel ? (st_q.cur && !st_q.prev) : (!st_q.cur && st_q.prev));

endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dir,
    input  logic             wr_dat,
    input  logic             wr_ctl,
    input  logic             rd_dat,
    input  logic [W-1:0]     wdata,
    input  logic [W-1:0]     pin_in,
    input  logic             sense_in,
    input  logic             aux_in,
    output logic [W-1:0]     pin_out,
    output logic [W-1:0]     pin_oe,
    output logic             aux_out,
    output logic             aux_oe,
    output logic             irq,
    output logic [CTL_W-1:0] ctl_view,
    output logic [W-1:0]     dat_view,
    output logic [W-1:0]     dir_view
);
    typedef struct packed {
        logic [W-1:0]     dir;
        logic [W-1:0]     lat;
        logic [W-1:0]     pin;
        logic [CFG_W-1:0] cfg;
        logic             flg_sns;
        logic             flg_aux;
        logic             pulse;
    } port_st_t;

    port_st_t  st_d, st_q;
    aux_mode_e mode;
    logic      sns_hit, aux_hit;

    assign mode = aux_mode(st_q.cfg[CB_AUX_DIR:CB_AUX_LO]);

    pio_edge u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (sense_in),
        .rise_sel (st_q.cfg[CB_SENSE_UP]),
        .hit      (sns_hit)
    );

    pio_edge u_aux (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (aux_in),
        .rise_sel (st_q.cfg[CB_AUX_MID]),
        .hit      (aux_hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pin   = pin_in;
        st_d.pulse = 1'b0;
        if (wr_dir) st_d.dir = wdata;
        if (wr_dat) begin
            st_d.lat   = wdata;
            st_d.pulse = (mode == AUX_PULSE);
        end
        if (wr_ctl) st_d.cfg = wdata[CFG_W-1:0];
        // a clearing read loses against a set in the same cycle
        if (rd_dat) begin
            st_d.flg_sns = 1'b0;
            st_d.flg_aux = 1'b0;
        end
        if (sns_hit)                       st_d.flg_sns = 1'b1;
        if (aux_hit && mode == AUX_SENSE)  st_d.flg_aux = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (mode)
            AUX_PULSE: aux_out = !st_q.pulse;
            AUX_LEVEL: aux_out = st_q.cfg[CB_AUX_LO];
            default:   aux_out = 1'b1;
        endcase
    end

    assign aux_oe   = st_q.cfg[CB_AUX_DIR];
    assign pin_out  = st_q.lat;
    assign pin_oe   = st_q.dir;
    assign irq      = (st_q.flg_sns && st_q.cfg[CB_IRQ_EN]) ||
                      (st_q.flg_aux && st_q.cfg[CB_AUX_LO] && !st_q.cfg[CB_AUX_DIR]);
    assign ctl_view = {st_q.flg_sns, st_q.flg_aux, st_q.cfg};
    assign dat_view = (st_q.lat & st_q.dir) | (st_q.pin & ~st_q.dir);
    assign dir_view = st_q.dir;

endmodule

// File: rtl/dual_pio.sv
module dual_pio
    import pio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic [W-1:0] pa_in,
    output logic [W-1:0] pa_out,
    output logic [W-1:0] pa_oe,
    input  logic         a_sense_in,
    input  logic         a_aux_in,
    output logic         a_aux_out,
    output logic         a_aux_oe,
    output logic         a_irq,
    input  logic [W-1:0] pb_in,
    output logic [W-1:0] pb_out,
    output logic [W-1:0] pb_oe,
    input  logic         b_sense_in,
    input  logic         b_aux_in,
    output logic         b_aux_out,
    output logic         b_aux_oe,
    output logic         b_irq
);
    localparam int NPORT = 2;

    logic [NPORT-1:0][W-1:0]     pin_in_v, pin_out_v, pin_oe_v, dat_v, dir_v;
    logic [NPORT-1:0][CTL_W-1:0] port_ctl;
    logic [NPORT-1:0]            sense_v, auxi_v, auxo_v, auxoe_v, irq_v;

    assign pin_in_v = {pb_in, pa_in};
    assign sense_v  = {b_sense_in, a_sense_in};
    assign auxi_v   = {b_aux_in, a_aux_in};

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        logic hit, even, wr_dir, wr_dat, wr_ctl, rd_dat;
        assign hit    = sel && (addr[1] == 1'(i));
        assign even   = hit && !addr[0];
        assign wr_dir = even && wr_en && !port_ctl[i][CB_DATA_SEL];
        assign wr_dat = even && wr_en &&  port_ctl[i][CB_DATA_SEL];
        assign wr_ctl = hit && addr[0] && wr_en;
        assign rd_dat = even && rd_en &&  port_ctl[i][CB_DATA_SEL];

        pio_port #(.W(W)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_dir   (wr_dir),
            .wr_dat   (wr_dat),
            .wr_ctl   (wr_ctl),
            .rd_dat   (rd_dat),
            .wdata    (wdata),
            .pin_in   (pin_in_v[i]),
            .sense_in (sense_v[i]),
            .aux_in   (auxi_v[i]),
            .pin_out  (pin_out_v[i]),
            .pin_oe   (pin_oe_v[i]),
            .aux_out  (auxo_v[i]),
            .aux_oe   (auxoe_v[i]),
            .irq      (irq_v[i]),
            .ctl_view (port_ctl[i]),
            .dat_view (dat_v[i]),
            .dir_view (dir_v[i])
        );
    end

    always_comb begin
        if (addr[0])                            rdata = W'(port_ctl[addr[1]]);
        else if (port_ctl[addr[1]][CB_DATA_SEL]) rdata = dat_v[addr[1]];
        else                                    rdata = dir_v[addr[1]];
    end

    assign pa_out    = pin_out_v[0];
    assign pa_oe     = pin_oe_v[0];
    assign a_aux_out = auxo_v[0];
    assign a_aux_oe  = auxoe_v[0];
    assign a_irq     = irq_v[0];
    assign pb_out    = pin_out_v[1];
    assign pb_oe     = pin_oe_v[1];
    assign b_aux_out = auxo_v[1];
    assign b_aux_oe  = auxoe_v[1];
    assign b_irq     = irq_v[1];

endmodule

// File: rtl/pio_chk.sv
module pio_chk #(
    parameter int W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [W-1:0]     wdata,
    input logic [W-1:0]     pa_oe,
    input logic [W-1:0]     pb_oe,
    input logic             a_aux_out,
    input logic             a_aux_oe,
    input logic             a_irq,
    input logic [1:0][7:0]  port_ctl
);
    logic a_even_wr, a_any_wr;
    assign a_even_wr = sel && wr_en && (addr == 2'd0);
    assign a_any_wr  = sel && wr_en && (addr[1] == 1'b0);

    // reset leaves every pin undriven
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (pa_oe == '0 && pb_oe == '0 && !a_aux_oe && !a_irq));

    // direction write through the shared address
    assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_even_wr && !port_ctl[0][2]) |=> (pa_oe == $past(wdata)));

    // strobe goes low after a data write in pulse mode
    assert_pulse_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (a_even_wr && port_ctl[0][2] && port_ctl[0][5:3] == 3'b101) |=> !a_aux_out);

    // strobe lasts one cycle only
    assert_pulse_short_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_aux_out && port_ctl[0][5:3] == 3'b101 && !a_any_wr) |=> a_aux_out);

    // interrupt silent when both enables are off
    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_ctl[0][0] && !port_ctl[0][3]) |-> !a_irq);

    // static level mode drives bit 3
    assert_aux_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (port_ctl[0][5:4] == 2'b11) |-> (a_aux_oe && a_aux_out == port_ctl[0][3]));

endmodule

bind dual_pio pio_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .pa_oe     (pa_oe),
    .pb_oe     (pb_oe),
    .a_aux_out (a_aux_out),
    .a_aux_oe  (a_aux_oe),
    .a_irq     (a_irq),
    .port_ctl  (port_ctl)
);

// File: tb/tb_dual_pio.sv
`timescale 1ns/1ps
module tb_dual_pio;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic [7:0] pa_in = '0, pa_out, pa_oe, pb_in = '0, pb_out, pb_oe;
    logic       a_sense_in = 1'b0, a_aux_in = 1'b0, a_aux_out, a_aux_oe, a_irq;
    logic       b_sense_in = 1'b0, b_aux_in = 1'b0, b_aux_out, b_aux_oe, b_irq;
    int         checks = 0, errors = 0;
    logic [7:0] v;

    always #5 clk = ~clk;

    dual_pio #(.W(8)) dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); sel = 1; wr_en = 1; addr = a; wdata = d;
        @(negedge clk); sel = 0; wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); sel = 1; rd_en = 1; addr = a;
        #1 d = rdata;
        @(negedge clk); sel = 0; rd_en = 0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 pa_oe", pa_oe, 8'h00);
        chk("R1 pb_oe", pb_oe, 8'h00);
        chk("R1 pa_out", pa_out, 8'h00);
        chk("R1 aux oe/out/irq", {5'b0, a_aux_oe, a_aux_out, a_irq}, 8'h02);
        rd(2'd1, v); chk("R1 ctl A", v, 8'h00);
        rd(2'd3, v); chk("R1 ctl B", v, 8'h00);
    endtask

    task automatic t_dir_and_data;
        wr(2'd0, 8'h0F);
        chk("R3 dir sets oe", pa_oe, 8'h0F);
        rd(2'd0, v); chk("R2 even reads dir", v, 8'h0F);
        wr(2'd1, 8'h04);
        wr(2'd0, 8'hA5);
        chk("R3 latch drives out", pa_out, 8'hA5);
        chk("R2 data write keeps dir", pa_oe, 8'h0F);
        @(negedge clk); pa_in = 8'h3C;
        rd(2'd0, v); chk("R4 mixed read", v, 8'h35);
        wr(2'd1, 8'h00);
        rd(2'd0, v); chk("R2 dir reselected", v, 8'h0F);
        wr(2'd1, 8'h04);
    endtask

    task automatic t_port_b;
        wr(2'd2, 8'hC0);
        chk("R2 B dir", pb_oe, 8'hC0);
        chk("R2 A dir untouched", pa_oe, 8'h0F);
        wr(2'd3, 8'h04);
        wr(2'd2, 8'hFF);
        chk("R2 B out", pb_out, 8'hFF);
        chk("R2 A out untouched", pa_out, 8'hA5);
        rd(2'd1, v); chk("R2 A ctl untouched", v, 8'h04);
    endtask

    task automatic t_ctl_ro;
        wr(2'd1, 8'hFF);
        rd(2'd1, v); chk("R5 flags read-only", v, 8'h3F);
        wr(2'd1, 8'h04);
    endtask

    task automatic t_sense;
        wr(2'd1, 8'h07);
        @(negedge clk); a_sense_in = 1;
        wait_n(2);
        rd(2'd1, v); chk("R6 rising sets bit7", v, 8'h87);
        chk("R9 irq enabled", {7'b0, a_irq}, 8'h01);
        rd(2'd1, v); chk("R8 ctl read keeps flag", v, 8'h87);
        rd(2'd0, v);
        rd(2'd1, v); chk("R8 data read clears", v, 8'h07);
        chk("R9 irq drops", {7'b0, a_irq}, 8'h00);
        @(negedge clk); a_sense_in = 0; wait_n(3);
        rd(2'd1, v); chk("R6 falling ignored in rising mode", v, 8'h07);
        wr(2'd1, 8'h05);
        @(negedge clk); a_sense_in = 1; wait_n(3);
        rd(2'd1, v); chk("R6 rising ignored in falling mode", v, 8'h05);
        @(negedge clk); a_sense_in = 0; wait_n(3);
        rd(2'd1, v); chk("R6 falling sets bit7", v, 8'h85);
        rd(2'd0, v);
        wr(2'd1, 8'h06);
        @(negedge clk); a_sense_in = 1; wait_n(3);
        rd(2'd1, v); chk("R9 flag without enable", v, 8'h86);
        chk("R9 irq masked", {7'b0, a_irq}, 8'h00);
        rd(2'd0, v);
        @(negedge clk); a_sense_in = 0; wait_n(3);
        @(negedge clk); a_sense_in = 1;
        rd(2'd0, v);
        rd(2'd1, v); chk("R8 set wins over clear", v, 8'h86);
        rd(2'd0, v);
    endtask

    task automatic t_aux_in;
        wr(2'd1, 8'h0C);
        chk("R11 aux undriven", {7'b0, a_aux_oe}, 8'h00);
        @(negedge clk); a_aux_in = 1; wait_n(3);
        rd(2'd1, v); chk("R7 rising ignored in falling mode", v, 8'h0C);
        @(negedge clk); a_aux_in = 0; wait_n(3);
        rd(2'd1, v); chk("R7 falling sets bit6", v, 8'h4C);
        chk("R9 irq from bit6", {7'b0, a_irq}, 8'h01);
        rd(2'd0, v);
        rd(2'd1, v); chk("R8 bit6 cleared", v, 8'h0C);
    endtask

    task automatic t_aux_out;
        wr(2'd1, 8'h2C);
        chk("R10 driven idle high", {6'b0, a_aux_oe, a_aux_out}, 8'h03);
        @(negedge clk); a_aux_in = 1; wait_n(3);
        @(negedge clk); a_aux_in = 0; wait_n(3);
        rd(2'd1, v); chk("R7 aux edges ignored when driven", v, 8'h2C);
        wr(2'd0, 8'h11);
        chk("R10 strobe low", {7'b0, a_aux_out}, 8'h00);
        @(negedge clk);
        chk("R10 strobe one cycle", {7'b0, a_aux_out}, 8'h01);
        chk("R3 latch after strobe write", pa_out, 8'h11);
        wr(2'd1, 8'h34);
        chk("R11 level low", {6'b0, a_aux_oe, a_aux_out}, 8'h02);
        wr(2'd1, 8'h3C);
        chk("R11 level high", {6'b0, a_aux_oe, a_aux_out}, 8'h03);
        wr(2'd1, 8'h24);
        chk("R11 mode 100 high", {6'b0, a_aux_oe, a_aux_out}, 8'h03);
        wr(2'd0, 8'h22);
        chk("R10 no strobe in mode 100", {7'b0, a_aux_out}, 8'h01);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_dir_and_data();
        t_port_b();
        t_ctl_ro();
        t_sense();
        t_aux_in();
        t_aux_out();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule